// File: doc/BRIEF.md
# Atomic-Alias Status Register with Level Interrupt

This block holds one 64-bit status and control word on a simple request/acknowledge register bus. Software reaches it at three consecutive word offsets. The first offset is a plain load and read location. The second and third are alias locations, and each one changes the word in a single bus write, so no read-modify-write sequence is needed. Only the upper 16 bits of the word exist. The lower 48 bits are forced to zero on every update and always read back as zero.

The most significant stored bit drives a level interrupt line. The line is registered and follows the stored bit on the same clock edge. The parameter `VARIANT` selects the behaviour of the second alias. With `VARIANT` = 0 it ANDs the write data into the word, and the word sits at word offset 0x4020. With `VARIANT` = 1 it clears the word whatever the write data is, and the word sits at word offset 0x6080. In both variants the third alias ORs the write data into the word.

The word offset is the byte address shifted right by three. Every request is acknowledged exactly one cycle after it is presented, and a new request may be presented in every cycle.

Top module: `alias_status_reg`

## Requirements
- R1: While reset is held and right after it is released, `ack` and `irq` are 0 and a read of the base offset returns 0.
- R2: An aligned write to the base offset (word offset BASE) stores the write data with bits 47:0 forced to zero. Bits 47:0 of `rdata` are always zero.
- R3: With VARIANT=0, an aligned write to word offset BASE+1 stores (old AND wdata), masked as in R2.
- R4: In both variants, an aligned write to word offset BASE+2 stores (old OR wdata), masked as in R2.
- R5: With VARIANT=1, an aligned write to word offset BASE+1 stores zero, whatever `wdata` is.
- R6: On the clock edge that performs any update, `irq` takes bit 63 of the new stored value. `irq` changes on no other edge.
- R7: An aligned read of word offset BASE returns the stored value in the acknowledge cycle. A read of any other offset returns zero, the two alias offsets included.
- R8: A write to any word offset other than BASE, BASE+1 and BASE+2 leaves the stored value and `irq` unchanged.
- R9: A request whose byte address has bits 2:0 non-zero is still acknowledged. As a write it changes nothing. As a read it returns zero.
- R10: `ack` is 1 in exactly the cycle after each cycle with `req` high and 0 otherwise, including back-to-back requests. BASE is 0x4020 for VARIANT=0 and 0x6080 for VARIANT=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one access per cycle |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | 64 | Byte address; the word offset is addr >> 3 |
| wdata | input | 64 | Write data; bit 63 is the most significant bus bit |
| rdata | output | 64 | Read data, valid in the acknowledge cycle, zero otherwise |
| ack | output | 1 | One-cycle acknowledge, the cycle after `req` |
| irq | output | 1 | Level interrupt, equal to the stored bit 63 |

## Verification
The hardest situation to reach is an update through an alias that leaves the interrupt level where it was, or that moves it only through bit 63 while the other kept bits change. Examples are an AND that keeps bit 63 and clears lower bits, an OR onto an already set word, and a clear of a word that is already zero. The bench walks through these cases in directed sequences. It then sends back-to-back random traffic over the three live offsets of both variants, their immediate neighbours and misaligned addresses. Write data has bit 63 forced high or low on part of the writes. Two instances, one per variant, see the same bus. Each one's bench model predicts its read data and interrupt every cycle, so aliases that belong to the other variant also act as unknown-offset writes.

// File: rtl/alias_status_pkg.sv
`timescale 1ns/1ps
package alias_status_pkg;
    // Update applied to the stored word in one cycle
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_ALT  = 2'd2,
        UPD_OR   = 2'd3
    } upd_op_e;

    // Behaviour of the second alias offset
    localparam int unsigned VARIANT_AND_OR = 0;
    localparam int unsigned VARIANT_CLR_OR = 1;
endpackage

// File: rtl/alias_decode.sv
`timescale 1ns/1ps
module alias_decode #(
    parameter int unsigned ADDR_W   = 64,
    parameter int unsigned BASE_OFF = 'h4020
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned,
    output logic              hit_base,
    output logic              hit_alt,
    output logic              hit_or
);
    localparam int unsigned WORD_W = ADDR_W - 3;
    localparam int unsigned N_OFF  = 3;

    logic [WORD_W-1:0] word_off;
    logic [N_OFF-1:0]  hit;

    assign word_off = addr[ADDR_W-1:3];
    assign aligned  = (addr[2:0] == 3'b000);

    for (genvar i = 0; i < N_OFF; i++) begin : g_match
        assign hit[i] = aligned && (word_off == WORD_W'(BASE_OFF + i));
    end

    assign hit_base = hit[0];
    assign hit_alt  = hit[1];
    assign hit_or   = hit[2];
endmodule

// File: rtl/alias_update.sv
`timescale 1ns/1ps
module alias_update
    import alias_status_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned KEEP_W  = 16,
    parameter int unsigned VARIANT = VARIANT_AND_OR
) (
    input  upd_op_e           op,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] nxt
);
    localparam int unsigned LOW_W = DATA_W - KEEP_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {LOW_W{1'b0}}};

    logic [DATA_W-1:0] alt_val;
    logic [DATA_W-1:0] raw;

    if (VARIANT == VARIANT_CLR_OR) begin : g_clear
        assign alt_val = '0;
    end else begin : g_and
        assign alt_val = cur & wdata;
    end

    always_comb begin
        case (op)
            UPD_LOAD: raw = wdata;
            UPD_ALT:  raw = alt_val;
            UPD_OR:   raw = cur | wdata;
            default:  raw = cur;
        endcase
        nxt = raw & KEEP_MASK;
    end
endmodule

// File: rtl/alias_status_reg.sv
`timescale 1ns/1ps
module alias_status_reg
    import alias_status_pkg::*;
#(
    parameter int unsigned VARIANT = VARIANT_AND_OR,
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned KEEP_W  = 16,
    parameter int unsigned OFF_A   = 'h4020,
    parameter int unsigned OFF_B   = 'h6080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              irq
);
    localparam int unsigned BASE_OFF = (VARIANT == VARIANT_CLR_OR) ? OFF_B : OFF_A;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              irq;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t            st_d, st_q;
    upd_op_e           op_d;
    logic              aligned_d, hit_base_d, hit_alt_d, hit_or_d;
    logic [DATA_W-1:0] val_upd_d;

    alias_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_OFF (BASE_OFF)
    ) u_decode (
        .addr     (addr),
        .aligned  (aligned_d),
        .hit_base (hit_base_d),
        .hit_alt  (hit_alt_d),
        .hit_or   (hit_or_d)
    );

    alias_update #(
        .DATA_W  (DATA_W),
        .KEEP_W  (KEEP_W),
        .VARIANT (VARIANT)
    ) u_update (
        .op    (op_d),
        .cur   (st_q.val),
        .wdata (wdata),
        .nxt   (val_upd_d)
    );

    always_comb begin
        op_d = UPD_NONE;
        if (req && we && aligned_d) begin
            if (hit_base_d)     op_d = UPD_LOAD;
            else if (hit_alt_d) op_d = UPD_ALT;
            else if (hit_or_d)  op_d = UPD_OR;
        end

        st_d       = st_q;
        st_d.ack   = req;
        st_d.rdata = '0;
        if (req && !we && hit_base_d) begin
            st_d.rdata = st_q.val;
        end
        if (op_d != UPD_NONE) begin
            st_d.val = val_upd_d;
            st_d.irq = val_upd_d[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign ack   = st_q.ack;
    assign irq   = st_q.irq;
endmodule

// File: rtl/alias_status_chk.sv
`timescale 1ns/1ps
module alias_status_chk #(
    parameter int unsigned VARIANT = 0,
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned KEEP_W  = 16,
    parameter int unsigned OFF_A   = 'h4020,
    parameter int unsigned OFF_B   = 'h6080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              wdata_msb,
    input logic [DATA_W-1:0] rdata,
    input logic              ack,
    input logic              irq
);
    localparam int unsigned BASE  = (VARIANT == 1) ? OFF_B : OFF_A;
    localparam int unsigned WW    = ADDR_W - 3;
    localparam int unsigned LOW_W = DATA_W - KEEP_W;

    logic aligned_c, at_base, at_alt, at_or, at_known;
    assign aligned_c = (addr[2:0] == 3'b000);
    assign at_base   = aligned_c && (addr[ADDR_W-1:3] == WW'(BASE));
    assign at_alt    = aligned_c && (addr[ADDR_W-1:3] == WW'(BASE + 1));
    assign at_or     = aligned_c && (addr[ADDR_W-1:3] == WW'(BASE + 2));
    assign at_known  = at_base || at_alt || at_or;

    p_ack_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);
    p_ack_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);
    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[LOW_W-1:0] == '0);
    p_base_write_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && at_base) |=> (irq == $past(wdata_msb)));
    p_or_sets_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && at_or && wdata_msb) |=> irq);
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && we && at_known) |=> $stable(irq));
    p_misaligned_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !aligned_c) |=> (rdata == '0));
    p_read_matches_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && at_base) |=> (rdata[DATA_W-1] == irq));

    if (VARIANT == 1) begin : g_chk_clear
        p_clear_drops_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req && we && at_alt) |=> !irq);
    end else begin : g_chk_and
        p_and_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (req && we && at_alt && !wdata_msb) |=> !irq);
    end
endmodule

bind alias_status_reg alias_status_chk #(
    .VARIANT (VARIANT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEEP_W  (KEEP_W),
    .OFF_A   (OFF_A),
    .OFF_B   (OFF_B)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .wdata_msb (wdata[DATA_W-1]),
    .rdata     (rdata),
    .ack       (ack),
    .irq       (irq)
);

// File: tb/tb_alias_status_reg.sv
`timescale 1ns/1ps
module tb_alias_status_reg;
    localparam int unsigned OFF_A = 'h4020;
    localparam int unsigned OFF_B = 'h6080;
    localparam logic [63:0] KEEP  = 64'hFFFF_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [63:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata_a, rdata_b;
    logic        ack_a, ack_b, irq_a, irq_b;

    int          vectors = 0;
    int          miscompares = 0;
    logic [63:0] m_a = '0;
    logic [63:0] m_b = '0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    alias_status_reg #(.VARIANT(0)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata_a), .ack(ack_a), .irq(irq_a)
    );

    alias_status_reg #(.VARIANT(1)) dut_b (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata_b), .ack(ack_b), .irq(irq_b)
    );

    function automatic logic [63:0] mdl_next(logic [63:0] cur, logic wr, logic [63:0] a,
                                             logic [63:0] d, int vsel, int unsigned base);
        logic [63:0] r = cur;
        logic [60:0] w = a[63:3];
        if (wr && a[2:0] == 3'b000) begin
            if (w == 61'(base))          r = d;
            else if (w == 61'(base + 1)) r = (vsel == 1) ? 64'd0 : (cur & d);
            else if (w == 61'(base + 2)) r = cur | d;
        end
        return r & KEEP;
    endfunction

    function automatic logic [63:0] mdl_read(logic [63:0] cur, logic wr, logic [63:0] a,
                                             int unsigned base);
        if (!wr && a[2:0] == 3'b000 && a[63:3] == 61'(base)) return cur;
        return 64'd0;
    endfunction

    function automatic string tag_of(logic wr, logic [63:0] a, int vsel, int unsigned base);
        logic [60:0] w = a[63:3];
        if (a[2:0] != 3'b000)   return "R9";
        if (w == 61'(base))     return wr ? "R2" : "R7";
        if (w == 61'(base + 1)) return wr ? ((vsel == 1) ? "R5" : "R3") : "R7";
        if (w == 61'(base + 2)) return wr ? "R4" : "R7";
        return wr ? "R8" : "R7";
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check its results at the next one
    task automatic step(logic wr, logic [63:0] a, logic [63:0] d);
        logic [63:0] ea, eb, na, nb;
        string ta, tb;
        req = 1'b1; we = wr; addr = a; wdata = d;
        ea = mdl_read(m_a, wr, a, OFF_A);
        eb = mdl_read(m_b, wr, a, OFF_B);
        na = mdl_next(m_a, wr, a, d, 0, OFF_A);
        nb = mdl_next(m_b, wr, a, d, 1, OFF_B);
        ta = tag_of(wr, a, 0, OFF_A);
        tb = tag_of(wr, a, 1, OFF_B);
        @(negedge clk);
        chk("R10", "ack A", {63'd0, ack_a}, 64'd1);
        chk("R10", "ack B", {63'd0, ack_b}, 64'd1);
        chk(ta, "rdata A", rdata_a, ea);
        chk(tb, "rdata B", rdata_b, eb);
        chk(wr ? "R6" : "R7", "irq A", {63'd0, irq_a}, {63'd0, na[63]});
        chk(wr ? "R6" : "R7", "irq B", {63'd0, irq_b}, {63'd0, nb[63]});
        m_a = na;
        m_b = nb;
    endtask

    task automatic idle();
        req = 1'b0; we = 1'b0;
        @(negedge clk);
        chk("R10", "idle ack A", {63'd0, ack_a}, 64'd0);
        chk("R10", "idle ack B", {63'd0, ack_b}, 64'd0);
        chk("R6", "idle irq A", {63'd0, irq_a}, {63'd0, m_a[63]});
        chk("R6", "idle irq B", {63'd0, irq_b}, {63'd0, m_b[63]});
        chk("R7", "idle rdata A", rdata_a, 64'd0);
    endtask

    function automatic logic [63:0] byte_addr(int unsigned off);
        return {3'b000, 61'(off)} << 3;
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        chk("R1", "reset ack A", {63'd0, ack_a}, 64'd0);
        chk("R1", "reset irq A", {63'd0, irq_a}, 64'd0);
        chk("R1", "reset irq B", {63'd0, irq_b}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        step(1'b0, byte_addr(OFF_A), 64'd0);
        step(1'b0, byte_addr(OFF_B), 64'd0);

        // Directed, AND/OR variant
        step(1'b1, byte_addr(OFF_A), 64'hFFFF_FFFF_FFFF_FFFF);
        step(1'b0, byte_addr(OFF_A), 64'd0);
        step(1'b1, byte_addr(OFF_A + 1), 64'hFFF0_FFFF_FFFF_FFFF);
        step(1'b1, byte_addr(OFF_A + 1), 64'h7FFF_0000_0000_0000);
        step(1'b0, byte_addr(OFF_A), 64'd0);
        step(1'b1, byte_addr(OFF_A + 2), 64'h8000_0000_0000_0001);
        step(1'b1, byte_addr(OFF_A + 2), 64'h8000_0000_0000_0000);
        step(1'b1, byte_addr(OFF_A) + 64'd3, 64'd0);
        step(1'b0, byte_addr(OFF_A) + 64'd4, 64'd0);
        step(1'b0, byte_addr(OFF_A + 1), 64'd0);
        step(1'b0, byte_addr(OFF_A + 2), 64'd0);
        step(1'b1, byte_addr(OFF_A + 3), 64'd0);
        step(1'b1, byte_addr(OFF_A - 1), 64'd0);
        step(1'b0, byte_addr(OFF_A), 64'd0);
        idle();

        // Directed, clear/OR variant
        step(1'b1, byte_addr(OFF_B), 64'hFFFF_FFFF_FFFF_FFFF);
        step(1'b1, byte_addr(OFF_B + 1), 64'hFFFF_FFFF_FFFF_FFFF);
        step(1'b0, byte_addr(OFF_B), 64'd0);
        step(1'b1, byte_addr(OFF_B + 1), 64'd0);
        step(1'b1, byte_addr(OFF_B + 2), 64'h8000_1234_5678_9ABC);
        step(1'b1, byte_addr(OFF_B + 2), 64'h0001_0000_0000_0000);
        step(1'b0, byte_addr(OFF_B), 64'd0);
        step(1'b1, byte_addr(OFF_B) + 64'd1, 64'd0);
        step(1'b1, byte_addr(OFF_B + 1) + 64'd7, 64'd0);
        step(1'b0, byte_addr(OFF_B), 64'd0);
        idle();

        // Back-to-back random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] a, d;
            logic        wr;
            int unsigned pick;
            if ($urandom_range(0, 9) == 0) begin
                idle();
                continue;
            end
            pick = $urandom_range(0, 8);
            case (pick)
                0, 1, 2: a = byte_addr(OFF_A + pick);
                3, 4, 5: a = byte_addr(OFF_B + pick - 3);
                6:       a = byte_addr(OFF_A + 3);
                7:       a = byte_addr(OFF_B - 1);
                default: a = {$urandom, $urandom} & ~64'd7;
            endcase
            if ($urandom_range(0, 6) == 0) a[2:0] = 3'($urandom_range(1, 7));
            wr = ($urandom_range(0, 9) < 6);
            d  = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0:       d[63] = 1'b1;
                1:       d[63] = 1'b0;
                default: ;
            endcase
            step(wr, a, d);
        end
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule